// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block divides the system clock down to the 16x oversampling tick that a UART's transmitter and receiver need. It emits a one-clock-wide enable pulse, not a derived clock. The consuming logic stays on the system clock and advances only in cycles where the tick is high.

Software configures the generator by writing one control word. The word carries an enable bit, a 12-bit divider value and a bit that selects a divide-by-16 prescaler ahead of the divider. The prescaler lets slow bit rates, whose divider would be 4096 or more, fit in the 12-bit field. When the generator is idle, a new word takes effect at the clock edge that writes it.

While the generator runs, a new word is held back until the current tick period ends. No period is ever cut short. The divider values themselves are computed by software.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset (`rst_n` low at a rising edge) the generator is disabled and `tick` stays low until a control word with the enable bit set is written.
- R2: Bit 16 of the control word enables the generator; a word written with bit 16 clear produces no ticks at all.
- R3: Bits 12:1 of the control word hold the divider value D (0 to 4095); with bit 0 clear, `tick` is high once every D+1 clocks, including the maximum D = 4095 (period 4096).
- R4: Bit 0 of the control word set inserts a divide-by-16 prescaler, giving one tick every 16*(D+1) clocks.
- R5: A write while the generator is disabled takes effect at the write edge; the first tick is high in the P-th cycle after that edge, where P is the tick period of the new word.
- R6: A write while the generator runs is deferred; the period in progress completes with its original length and tick, and the new period applies from the following cycle.
- R7: Clearing the enable bit while running lets the period in progress finish with its tick, after which no tick appears.
- R8: With a period greater than one, `tick` is high for exactly one clock per period; with D = 0 and no prescaler, `tick` is high in every cycle.
- R9: Control word bits 15:13 are ignored and do not change the tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_word | input | 17 | Control word: bit 16 enable, bits 12:1 divider, bit 0 prescaler select |
| tick | output | 1 | One-clock enable pulse at 16x the bit rate |

## Verification
The tick output is decoded from registers with no further output stage. After a write to an idle generator, the first tick is therefore due in the P-th cycle after the write edge, and every later tick is due exactly P cycles after the previous one. The bench drives inputs and samples `tick` on falling edges. It counts falling edges from the write, or from the previous tick, and compares that count with the period worked out from the written divider and prescaler bits. For a deferred rewrite, it counts the cycles spent before the write so that the remaining part of the old period is predicted exactly.

// File: rtl/baud_tick_pkg.sv
// Package: shared widths and the decoded configuration record of the
// baud tick generator. Assumes a 12-bit divider and a 16:1 prescaler.
package baud_tick_pkg;
    parameter int DIV_W   = 12;
    parameter int PRE_DIV = 16;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic             pre;
    } gen_cfg_t;
endpackage

// File: rtl/baud_cfg_reg.sv
// Module: holds the active configuration and a pending one. A write applies
// at once when idle or on a terminal tick, otherwise it waits for the next
// tick. Assumes tick is decoded from registered state only.
module baud_cfg_reg
    import baud_tick_pkg::*;
#(
    parameter int CTRL_W  = 17,
    parameter int EN_BIT  = 16,
    parameter int DIV_LSB = 1,
    parameter int PRE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              tick,
    output gen_cfg_t          act_cfg,
    output gen_cfg_t          nxt_cfg,
    output logic              apply
);
    localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

    gen_cfg_t act_q, pend_q, wr_cfg;
    logic     pend_v;

    // Decode the written word into the configuration record.
    always_comb begin
        wr_cfg.en  = ctrl_word[EN_BIT];
        wr_cfg.div = ctrl_word[DIV_MSB:DIV_LSB];
        wr_cfg.pre = ctrl_word[PRE_BIT];
    end

    // Choose when and what to load into the active configuration.
    always_comb begin
        apply   = (ctrl_wr && (!act_q.en || tick)) || (pend_v && tick);
        nxt_cfg = ctrl_wr ? wr_cfg : pend_q;
    end

    // Active and pending configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else begin
            if (apply) begin
                act_q  <= nxt_cfg;
                pend_v <= 1'b0;
            end else if (ctrl_wr) begin
                pend_q <= wr_cfg;
                pend_v <= 1'b1;
            end
        end
    end

    assign act_cfg = act_q;

    assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(act_q));
    assert_write_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && act_q.en && !tick) |=> pend_v);
endmodule

// File: rtl/baud_prescaler.sv
// Module: optional divide-by-PRE_DIV strobe. When bypassed, the strobe is
// high in every cycle. Restart clears the phase so that a new period starts aligned.
module baud_prescaler #(
    parameter int PRE_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic use_pre,
    output logic stb
);
    localparam int PW = $clog2(PRE_DIV);
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] pcnt;

    // Phase counter, active only while the prescaler is selected.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            pcnt <= '0;
        else if (use_pre)
            pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
    end

    assign stb = !use_pre || (pcnt == LAST);

    assert_pre_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (use_pre && !restart && pcnt != LAST) |=> pcnt == $past(pcnt) + 1'b1);
endmodule

// File: rtl/baud_divider.sv
// Module: down-counter that flags terminal count on a strobe cycle. It
// reloads from the active divider at terminal count, or from the new value on restart.
module baud_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stb,
    input  logic             restart,
    input  logic [DIV_W-1:0] new_div,
    input  logic [DIV_W-1:0] cur_div,
    output logic             tc
);
    logic [DIV_W-1:0] cnt;

    assign tc = run && stb && (cnt == '0);

    // Count strobes down to zero, then reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= new_div;
        else if (run && stb)
            cnt <= (cnt == '0) ? cur_div : cnt - 1'b1;
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(restart) |-> cnt <= cur_div);
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !restart) |=> cnt == $past(cur_div));
endmodule

// File: rtl/baud_tick_gen.sv
// Module: top of the baud tick generator. It joins the configuration
// register, the prescaler and the divider. The tick is a clock enable.
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int CTRL_W  = 17,
    parameter int EN_BIT  = 16,
    parameter int DIV_LSB = 1,
    parameter int PRE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              tick
);
    gen_cfg_t act_cfg, nxt_cfg;
    logic     apply, stb;

    baud_cfg_reg #(
        .CTRL_W(CTRL_W), .EN_BIT(EN_BIT), .DIV_LSB(DIV_LSB), .PRE_BIT(PRE_BIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
        .tick(tick), .act_cfg(act_cfg), .nxt_cfg(nxt_cfg), .apply(apply)
    );

    baud_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(apply),
        .use_pre(act_cfg.pre), .stb(stb)
    );

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(act_cfg.en), .stb(stb),
        .restart(apply), .new_div(nxt_cfg.div), .cur_div(act_cfg.div),
        .tc(tick)
    );

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !act_cfg.en |-> !tick);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [16:0] ctrl_word = '0;
    logic        tick;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .ctrl_word(ctrl_word), .tick(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [16:0] mk(input bit en, input int d, input bit pre);
        return {en, 3'b000, 12'(d), pre};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctrl_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive a word for one edge; returns at the following falling edge.
    task automatic write(input logic [16:0] w);
        ctrl_word = w;
        ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    // Count falling edges until tick is seen (current edge is index 0).
    task automatic find_tick(input int limit, output int n);
        n = 0;
        while (!tick && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic gap(input int limit, output int g);
        int n;
        @(negedge clk);
        find_tick(limit, n);
        g = n + 1;
    endtask

    task automatic count_ticks(input int cycles, output int c);
        c = 0;
        for (int i = 0; i < cycles; i++) begin
            if (tick) c++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int c;
        do_reset();
        count_ticks(40, c);
        check("R1 ticks after reset", c, 0);
    endtask

    task automatic t_disabled_word();
        int c;
        do_reset();
        write(mk(1'b0, 3, 1'b0));
        count_ticks(60, c);
        check("R2 ticks with enable clear", c, 0);
    endtask

    task automatic t_plain(input int d);
        int n, g;
        do_reset();
        write(mk(1'b1, d, 1'b0));
        find_tick(10000, n);
        check("R5 first tick index", n, d);
        gap(10000, g);
        check("R3 period", g, d + 1);
        gap(10000, g);
        check("R3 period repeat", g, d + 1);
    endtask

    task automatic t_pre(input int d);
        int n, g;
        do_reset();
        write(mk(1'b1, d, 1'b1));
        find_tick(10000, n);
        check("R5 first tick index with prescaler", n, 16 * (d + 1) - 1);
        gap(10000, g);
        check("R4 prescaled period", g, 16 * (d + 1));
    endtask

    task automatic t_every_cycle();
        int c;
        do_reset();
        write(mk(1'b1, 0, 1'b0));
        count_ticks(12, c);
        check("R8 D=0 tick every cycle", c, 12);
    endtask

    task automatic t_single_width();
        int n;
        do_reset();
        write(mk(1'b1, 3, 1'b0));
        find_tick(100, n);
        @(negedge clk);
        check("R8 tick low after pulse", int'(tick), 0);
    endtask

    task automatic t_deferred();
        int n, g;
        do_reset();
        write(mk(1'b1, 9, 1'b0));
        find_tick(100, n);
        repeat (4) @(negedge clk);
        write(mk(1'b1, 2, 1'b0));
        find_tick(100, n);
        check("R6 old period completes", n, 5);
        gap(100, g);
        check("R6 new period applied", g, 3);
    endtask

    task automatic t_stop();
        int n, c;
        do_reset();
        write(mk(1'b1, 5, 1'b0));
        find_tick(100, n);
        repeat (2) @(negedge clk);
        write(mk(1'b0, 5, 1'b0));
        find_tick(100, n);
        check("R7 final tick index", n, 3);
        @(negedge clk);
        count_ticks(100, c);
        check("R7 ticks after disable", c, 0);
    endtask

    task automatic t_ignored_bits();
        int n, g;
        do_reset();
        write(mk(1'b1, 4, 1'b0) | 17'h0E000);
        find_tick(100, n);
        gap(100, g);
        check("R9 period with bits 15:13 set", g, 5);
    endtask

    initial begin
        t_reset();
        t_disabled_word();
        t_plain(0);
        t_plain(7);
        t_plain(4095);
        t_pre(0);
        t_pre(2);
        t_every_cycle();
        t_single_width();
        t_deferred();
        t_stop();
        t_ignored_bits();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule